// File: doc/BRIEF.md
# Dithered Phase-Offset NCO Core

This block is a numerically controlled oscillator. A 32-bit phase register advances by a tuning word on every clock and wraps modulo 2^32, so the output frequency is the tuning word times the clock rate divided by 2^32. The tuning word may range from 0 to 2^31. A new tuning word only changes the step size. The running phase is never reset by such a change, so frequency hops stay phase-continuous.

A 14-bit phase offset, aligned to the top of the 32-bit phase, is added after the accumulator. The sum is then cut down to a 14-bit phase word. Before that cut, an optional pseudo-random value from a 16-bit maximal-length LFSR can be added into the bits that the cut discards. This spreads the spurs that the truncation causes. The truncated phase drives a quarter-wave sine table with quadrant folding. The block presents both the truncated phase and a signed 14-bit sample. A synchronous clear input zeroes the accumulator, and a clear wins over accumulation on the same edge.

Top module: `nco_core`

## Requirements
- R1: While `rst` is high at a clock edge, `phaseOut` and `ampOut` read zero after that edge, and the phase accumulator reads zero.
- R2: On every edge without reset or clear, the accumulator becomes its old value plus the `tuneWord` sampled at that edge, modulo 2^32.
- R3: With dither off, the `phaseOut` set by edge E+2 equals bits 31:18 of (accumulator after edge E) + (`phaseOffset` sampled at E shifted left by 18), taken modulo 2^32. This is a latency of three edges from the inputs to the outputs.
- R4: A change of `tuneWord` leaves the accumulator untouched. Only the step applied from the next edge onward changes, so the phase stays continuous.
- R5: `phaseOffset` occupies bits 31:18 of the 32-bit phase sum. It moves `phaseOut` by exactly its own value, modulo 2^14.
- R6: `clearAcc` high at an edge sets the accumulator to zero at that edge, whatever `tuneWord` holds.
- R7: With `ditherEn` low at the input edge, the dither contribution is zero. With it high, the added value stays below 2^16, so `phaseOut` equals the undithered value or that value plus one, modulo 2^14.
- R8: The amplitude depends only on `phaseOut[13:4]`. The quadrant is q = `phaseOut[13:12]` and the index is k = `phaseOut[11:4]`. For odd q the index is mirrored to 255-k. The magnitude is round(8191·sin(π(2k+1)/1024)). The sample is negative for q = 2 and q = 3, in two's complement.
- R9: The accumulator wraps modulo 2^32. Two steps of 2^31 from zero return it to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tuneWord | input | 32 | Phase increment per clock |
| phaseOffset | input | 14 | Phase offset, top-aligned |
| ditherEn | input | 1 | Adds LFSR dither below the truncation point |
| clearAcc | input | 1 | Synchronous accumulator clear |
| phaseOut | output | 14 | Truncated phase word |
| ampOut | output | 14 | Signed sine sample |

## Verification
The assertions assume that the inputs are stable and known around each clock edge. They also assume that at least three non-reset edges have passed before any latency relation is judged. The checker gates its pipeline properties with its own count of edges since reset, which covers that second assumption. The bench changes inputs only on falling edges, keeps `tuneWord` within 0 to 2^31, and lets reset cover more than three edges before any stimulus.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef struct packed {
    logic clearPhase;
    logic injectDither;
  } nco_strobe_t;

  localparam real PI_VAL = 3.14159265358979323846;

  function automatic int quarterMag(input int k, input int depth, input int peak);
    real angle;
    angle = PI_VAL * (2.0 * k + 1.0) / (4.0 * depth);
    return $rtoi($floor(peak * $sin(angle) + 0.5));
  endfunction

  function automatic logic [31:0] lfsrTaps(input int width);
    case (width)
      8:       return 32'h0000_00B8;
      24:      return 32'h00E1_0000;
      32:      return 32'h8020_0003;
      default: return 32'h0000_B400;
    endcase
  endfunction

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ditherEn,
  input  logic              clearAcc,
  output nco_strobe_t       strobes,
  output logic [LFSR_W-1:0] ditherWord
);
  localparam logic [31:0] TAPS = lfsrTaps(LFSR_W);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

  logic [LFSR_W-1:0] lfsrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsrQ <= SEED;
    end else if (lfsrQ[0]) begin
      lfsrQ <= (lfsrQ >> 1) ^ TAPS[LFSR_W-1:0];
    end else begin
      lfsrQ <= lfsrQ >> 1;
    end
  end

  always_comb begin
    strobes.clearPhase   = clearAcc;
    strobes.injectDither = ditherEn;
    ditherWord           = lfsrQ;
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 14,
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 14,
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  nco_strobe_t       strobes,
  input  logic [LFSR_W-1:0] ditherWord,
  input  logic [ACC_W-1:0]  tuneWord,
  input  logic [PH_W-1:0]   phaseOffset,
  output logic [ACC_W-1:0]  accPhase,
  output logic [PH_W-1:0]   phaseOut,
  output logic [AMP_W-1:0]  ampOut
);
  localparam int CUT      = ACC_W - PH_W;
  localparam int DEPTH    = 1 << LUT_AW;
  localparam int IDX_LSB  = PH_W - 2 - LUT_AW;
  localparam int PEAK     = (1 << (AMP_W - 1)) - 1;

  logic [ACC_W-1:0]  accQ;
  logic [PH_W-1:0]   offQ;
  logic [ACC_W-1:0]  ditQ;
  logic [PH_W-1:0]   truncQ;
  logic [PH_W-1:0]   phaseQ;
  logic [AMP_W-1:0]  ampQ;
  logic [AMP_W-2:0]  rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int MAG = quarterMag(i, DEPTH, PEAK);
    assign rom[i] = (AMP_W-1)'(MAG);
  end

  // stage 0: accumulate, capture offset and dither
  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
      offQ <= '0;
      ditQ <= '0;
    end else begin
      accQ <= strobes.clearPhase ? '0 : accQ + tuneWord;
      offQ <= phaseOffset;
      ditQ <= strobes.injectDither ? ACC_W'(ditherWord) : '0;
    end
  end

  // stage 1: offset, dither, truncate
  logic [ACC_W-1:0] phaseSum;
  always_comb phaseSum = accQ + {offQ, {CUT{1'b0}}} + ditQ;

  always_ff @(posedge clk) begin
    if (rst) truncQ <= '0;
    else     truncQ <= phaseSum[ACC_W-1:CUT];
  end

  // stage 2: quadrant folding and lookup
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [AMP_W-2:0]  mag;
  logic [AMP_W-1:0]  signedAmp;
  always_comb begin
    quad      = truncQ[PH_W-1 -: 2];
    idx       = truncQ[IDX_LSB +: LUT_AW];
    if (quad[0]) idx = ~idx;
    mag       = rom[idx];
    signedAmp = quad[1] ? -{1'b0, mag} : {1'b0, mag};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= '0;
      ampQ   <= '0;
    end else begin
      phaseQ <= truncQ;
      ampQ   <= signedAmp;
    end
  end

  assign accPhase = accQ;
  assign phaseOut = phaseQ;
  assign ampOut   = ampQ;
endmodule

// File: rtl/nco_core.sv
module nco_core
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 14,
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 14,
  parameter int LFSR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tuneWord,
  input  logic [PH_W-1:0]  phaseOffset,
  input  logic             ditherEn,
  input  logic             clearAcc,
  output logic [PH_W-1:0]  phaseOut,
  output logic [AMP_W-1:0] ampOut
);
  nco_strobe_t       strobes;
  logic [LFSR_W-1:0] ditherWord;
  logic [ACC_W-1:0]  accPhase;

  nco_ctrl #(.LFSR_W(LFSR_W)) u_ctrl (
    .clk(clk), .rst(rst), .ditherEn(ditherEn), .clearAcc(clearAcc),
    .strobes(strobes), .ditherWord(ditherWord)
  );

  nco_datapath #(
    .ACC_W(ACC_W), .PH_W(PH_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W), .LFSR_W(LFSR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .ditherWord(ditherWord),
    .tuneWord(tuneWord), .phaseOffset(phaseOffset), .accPhase(accPhase),
    .phaseOut(phaseOut), .ampOut(ampOut)
  );
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 14,
  parameter int AMP_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] tuneWord,
  input logic [PH_W-1:0]  phaseOffset,
  input logic             ditherEn,
  input logic             clearAcc,
  input logic [ACC_W-1:0] accPhase,
  input logic [PH_W-1:0]  phaseOut,
  input logic [AMP_W-1:0] ampOut
);
  localparam int CUT = ACC_W - PH_W;
  logic [2:0] sinceRst = '0;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (phaseOut == '0 && ampOut == '0 && accPhase == '0));

  assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !clearAcc |=> accPhase == $past(accPhase) + $past(tuneWord));

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    clearAcc |=> accPhase == '0);

  assert_latency_exact_R3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd3 && !$past(ditherEn, 3)) |->
      phaseOut == PH_W'(($past(accPhase, 2) + {$past(phaseOffset, 3), {CUT{1'b0}}}) >> CUT));

  assert_dither_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd3) |->
      PH_W'(phaseOut - PH_W'(($past(accPhase, 2) + {$past(phaseOffset, 3), {CUT{1'b0}}}) >> CUT)) <= PH_W'(1));

  assert_amp_sign_R8: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd1) |-> ampOut[AMP_W-1] == phaseOut[PH_W-1]);
endmodule

bind nco_core nco_core_chk #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .tuneWord(tuneWord), .phaseOffset(phaseOffset),
  .ditherEn(ditherEn), .clearAcc(clearAcc), .accPhase(accPhase),
  .phaseOut(phaseOut), .ampOut(ampOut)
);

// File: tb/tb_nco_core.sv
module tb_nco_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic [31:0] ftw;
    logic [13:0] off;
    logic        dith;
    logic        clr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0100_0000, 14'h0000, 1'b0, 1'b0},
    '{32'h0100_0000, 14'h0000, 1'b0, 1'b0},
    '{32'h0123_4567, 14'h0000, 1'b0, 1'b0},
    '{32'h8000_0000, 14'h0000, 1'b0, 1'b0},
    '{32'h8000_0000, 14'h1000, 1'b0, 1'b0},
    '{32'h7FFF_FFFF, 14'h2000, 1'b0, 1'b0},
    '{32'h0000_0001, 14'h3FFF, 1'b0, 1'b0},
    '{32'h4000_0000, 14'h0000, 1'b0, 1'b1},
    '{32'h4000_0000, 14'h0800, 1'b0, 1'b0},
    '{32'h0004_0000, 14'h0005, 1'b0, 1'b0},
    '{32'h0004_0000, 14'h3FF0, 1'b1, 1'b0},
    '{32'h1357_9BDF, 14'h1234, 1'b1, 1'b0},
    '{32'h0000_0000, 14'h0000, 1'b1, 1'b1},
    '{32'h0000_0000, 14'h2ABC, 1'b0, 1'b0},
    '{32'h2000_0000, 14'h0000, 1'b0, 1'b0},
    '{32'h2000_0000, 14'h0000, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tuneWord = '0;
  logic [13:0] phaseOffset = '0;
  logic        ditherEn = 1'b0;
  logic        clearAcc = 1'b0;
  logic [13:0] phaseOut;
  logic [13:0] ampOut;

  int nChecks = 0;
  int nFails  = 0;

  nco_core dut (
    .clk(clk), .rst(rst), .tuneWord(tuneWord), .phaseOffset(phaseOffset),
    .ditherEn(ditherEn), .clearAcc(clearAcc), .phaseOut(phaseOut), .ampOut(ampOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // requirement-level model
  logic [31:0] mAcc;
  logic [13:0] mOff, mSum, mOut;
  logic        mDith, mSumD, mOutD;
  always @(posedge clk) begin
    if (rst) begin
      mAcc <= '0; mOff <= '0; mDith <= 1'b0;
      mSum <= '0; mSumD <= 1'b0; mOut <= '0; mOutD <= 1'b0;
    end else begin
      mOut  <= mSum;
      mOutD <= mSumD;
      mSum  <= 14'((mAcc + {mOff, 18'b0}) >> 18);
      mSumD <= mDith;
      mAcc  <= clearAcc ? 32'h0 : mAcc + tuneWord;
      mOff  <= phaseOffset;
      mDith <= ditherEn;
    end
  end

  function automatic int expAmp(input logic [13:0] p);
    int k;
    int mag;
    k = int'(p[11:4]);
    if (p[12]) k = 255 - k;
    mag = $rtoi($floor(8191.0 * $sin(3.14159265358979323846 * (2.0 * k + 1.0) / 1024.0) + 0.5));
    return p[13] ? -mag : mag;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    int a;
    a = $signed(ampOut);
    if (mOutD) begin
      nChecks++;
      if (phaseOut != mOut && phaseOut != 14'(mOut + 14'd1)) begin
        nFails++;
        $display("FAIL R7 %s: actual %0d expected %0d or +1", tag, phaseOut, mOut);
      end
    end else begin
      check({"R2 R3 R4 R5 R6 R9 ", tag}, int'(phaseOut), int'(mOut));
    end
    check({"R8 ", tag}, a, expAmp(phaseOut));
  endtask

  task automatic apply(input vec_t v);
    tuneWord = v.ftw; phaseOffset = v.off; ditherEn = v.dith; clearAcc = v.clr;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    tuneWord = 32'h1234_5678;
    phaseOffset = 14'h1111;
    repeat (5) @(negedge clk);
    // R1: reset holds outputs at zero
    check("R1 phase in reset", int'(phaseOut), 0);
    check("R1 amp in reset", int'(ampOut), 0);
    apply('{32'h0, 14'h0, 1'b0, 1'b0});
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      checkOutputs($sformatf("vec%0d", i));
    end
    apply('{32'h0, 14'h0, 1'b0, 1'b0});
    repeat (4) begin
      @(negedge clk);
      checkOutputs("flush");
    end

    // R9: two half-turn steps bring accumulator back to zero
    apply('{32'h0, 14'h0, 1'b0, 1'b1});
    @(negedge clk);
    apply('{32'h8000_0000, 14'h0, 1'b0, 1'b0});
    repeat (2) @(negedge clk);
    apply('{32'h0, 14'h0, 1'b0, 1'b0});
    repeat (3) @(negedge clk);
    check("R9 wrap to zero", int'(phaseOut), 0);

    // R6: clear wins over a large tuning word; output shows offset only
    apply('{32'h3FFF_FFFF, 14'h0ABC, 1'b0, 1'b1});
    @(negedge clk);
    apply('{32'h0, 14'h0ABC, 1'b0, 1'b0});
    repeat (3) @(negedge clk);
    check("R6 clear priority", int'(phaseOut), 32'h0ABC);

    // R8: low four phase bits do not change the amplitude
    apply('{32'h0, 14'h1230, 1'b0, 1'b1});
    repeat (3) @(negedge clk);
    check("R8 phase base", int'(phaseOut), 32'h1230);
    begin
      int base;
      base = $signed(ampOut);
      apply('{32'h0, 14'h123F, 1'b0, 1'b1});
      repeat (3) @(negedge clk);
      check("R8 low bits ignored", $signed(ampOut), base);
    end

    // R5 and R8: quadrant boundaries via offset alone
    apply('{32'h0, 14'h2000, 1'b0, 1'b1});
    repeat (3) @(negedge clk);
    check("R5 offset top aligned", int'(phaseOut), 32'h2000);
    check("R8 third quadrant negative", $signed(ampOut), -25);

    // R4: tuning word change keeps accumulated phase
    apply('{32'h0400_0000, 14'h0, 1'b0, 1'b1});
    @(negedge clk);
    apply('{32'h0400_0000, 14'h0, 1'b0, 1'b0});
    repeat (3) @(negedge clk);
    apply('{32'h0100_0000, 14'h0, 1'b0, 1'b0});
    repeat (4) begin
      @(negedge clk);
      checkOutputs("R4 hop");
    end

    // R7: long dithered run, every sample within one LSB
    apply('{32'h0135_79BD, 14'h0321, 1'b1, 1'b0});
    repeat (300) begin
      @(negedge clk);
      checkOutputs("R7 dither run");
    end
    apply('{32'h0135_79BD, 14'h0321, 1'b0, 1'b0});
    repeat (6) begin
      @(negedge clk);
      checkOutputs("R7 dither off");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule